// File: doc/BRIEF.md
# Mains Phase-Angle TRIAC Gate Controller

This block drives a TRIAC gate at a programmable phase angle within each mains half-cycle. It watches a zero-cross detector signal and treats each of its edges, rising or falling, as a mains crossing. At each edge it latches the value of an external free-running 16-bit tick counter. The counter is never stopped or reloaded. All timing is worked out from the difference between the current count and the latched stamp, using modulo-2^16 arithmetic. The interval between two successive stamps gives the measured half-period, so the firing point follows the real mains frequency.

From the measured half-period the block derives a guard interval of about 6 degrees at each end of the half-cycle. It then maps an 8-bit conduction request onto the span between the two guards. It also enforces a minimum delay from the crossing. The gate can either be held steady through the conduction window or be chopped at a programmable rate. If the mains edges stop arriving, a watchdog takes the gate low and raises a fault.

Top module: `triac_phase_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first firing, `gate_o` and `fault_o` are 0.
- R2: Every change of `zc_i` is a crossing. The half-period P is `cnt_i` at this crossing minus `cnt_i` at the previous one, taken modulo 2^16, so a counter wrap between the two does not change P.
- R3: The first crossing after reset only records a stamp. No gate pulse occurs in the half-cycle that follows it.
- R4: The guard interval is G = (P>>5) + (P>>9) ticks. The gate is never high at an elapsed count below G. It goes low once the elapsed count reaches P − G, and it is low in the cycle in which a crossing is taken.
- R5: For a conduction request A (8 bits, 1..255), the firing delay is D = G + (((P − 2G)·(255 − A)) >> 8). With steady burst off, the gate is high exactly for elapsed counts in [D, P − G). The elapsed count is `cnt_i` minus the stamp, modulo 2^16.
- R6: A = 0 means off. The gate stays low for that whole half-cycle.
- R7: The delay is never below MIN_DLY ticks (default 16). When D < MIN_DLY, firing starts at MIN_DLY.
- R8: `angle_i` is sampled only at a crossing. A change part-way through a half-cycle affects only the next half-cycle.
- R9: With `burst_en_i` = 1 and `burst_half_i` = H, the gate inside the window is high for H+1 clock cycles, then low for H+1, and so on. The pattern starts with a high phase at the firing point.
- R10: If the elapsed count exceeds P + (P>>1) with no crossing, `fault_o` goes to 1 and the gate stays low. The fault clears at the next crossing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | 16 | Free-running tick counter value |
| zc_i | input | 1 | Synchronised zero-cross detector level |
| angle_i | input | 8 | Conduction request, 0 = off, 255 = widest |
| burst_en_i | input | 1 | 1 = chop the gate, 0 = hold it steady |
| burst_half_i | input | 8 | Burst half-period minus one, in clock cycles |
| gate_o | output | 1 | TRIAC gate drive |
| fault_o | output | 1 | Missing-crossing fault |

## Verification
The stamp is taken at the first rising clock edge where `zc_i` differs from its registered copy. `gate_o` reflects the elapsed count seen at a rising edge from just after that edge. As a result, the gate state for elapsed count j appears after the j-th rising edge following the crossing edge, and `fault_o` reaches 1 after the edge where the elapsed count first exceeds the limit. The bench advances `cnt_i` by one per clock and samples on the falling edge that follows each rising edge. This lets it index every sample by its elapsed count and compare the first high index and the high count with values computed from the formulas above. Because a half-cycle uses the period measured at its opening crossing, each vector is run twice and only the second run is checked.

// File: rtl/triac_phase_ctrl.sv
module triac_phase_ctrl #(
  parameter int CW      = 16,
  parameter int AW      = 8,
  parameter int BW      = 8,
  parameter int MIN_DLY = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic          zc_i,
  input  logic [AW-1:0] angle_i,
  input  logic          burst_en_i,
  input  logic [BW-1:0] burst_half_i,
  output logic          gate_o,
  output logic          fault_o
);
  localparam int PW = CW + AW;
  localparam logic [AW-1:0] AMAX  = {AW{1'b1}};
  localparam logic [CW-1:0] MIN_D = CW'(MIN_DLY);

  logic          zc_q, have_cap, per_ok, armed, fault_q, ph_q, gate_q;
  logic [CW-1:0] cap_q, dly_q, off_q;
  logic [CW:0]   lim_q;
  logic [BW-1:0] bc_q;

  logic          zc_edge, level, timeout;
  logic [CW-1:0] span, dz, win, raw, dly;
  logic [PW-1:0] prod;
  logic [CW:0]   lim;

  assign zc_edge = zc_i ^ zc_q;
  assign span    = cnt_i - cap_q;
  assign dz      = (span >> 5) + (span >> 9);
  assign win     = span - (dz << 1);
  assign prod    = PW'(win) * PW'(AMAX - angle_i);
  assign raw     = dz + prod[PW-1:AW];
  assign dly     = (raw < MIN_D) ? MIN_D : raw;
  assign lim     = {1'b0, span} + {2'b00, span[CW-1:1]};
  assign level   = armed && (span >= dly_q) && (span < off_q);
  assign timeout = per_ok && ({1'b0, span} > lim_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zc_q     <= 1'b0;
      have_cap <= 1'b0;
      per_ok   <= 1'b0;
      armed    <= 1'b0;
      fault_q  <= 1'b0;
      cap_q    <= '0;
      dly_q    <= '0;
      off_q    <= '0;
      lim_q    <= '0;
    end else begin
      zc_q <= zc_i;
      if (zc_edge) begin
        cap_q    <= cnt_i;
        have_cap <= 1'b1;
        per_ok   <= have_cap;
        armed    <= have_cap && (angle_i != '0);
        fault_q  <= 1'b0;
        dly_q    <= dly;
        off_q    <= span - dz;
        lim_q    <= lim;
      end else begin
        if (timeout) fault_q <= 1'b1;
        if (timeout || span >= off_q) armed <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bc_q   <= '0;
      ph_q   <= 1'b1;
      gate_q <= 1'b0;
    end else begin
      if (!level || zc_edge) begin
        bc_q <= '0;
        ph_q <= 1'b1;
      end else if (bc_q == burst_half_i) begin
        bc_q <= '0;
        ph_q <= ~ph_q;
      end else begin
        bc_q <= bc_q + 1'b1;
      end
      gate_q <= level && !zc_edge && (ph_q || !burst_en_i);
    end
  end

  assign gate_o  = gate_q;
  assign fault_o = fault_q;
endmodule

// File: rtl/triac_phase_ctrl_chk.sv
module triac_phase_ctrl_chk #(
  parameter int CW      = 16,
  parameter int AW      = 8,
  parameter int MIN_DLY = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt_i,
  input logic [CW-1:0] cap_q,
  input logic          zc_i,
  input logic          zc_q,
  input logic [AW-1:0] angle_i,
  input logic          armed,
  input logic          gate_o,
  input logic          fault_o
);
  AST_FAULT_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !gate_o); // R10

  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && (zc_i == zc_q)) |=> fault_o); // R10

  AST_ZERO_ANGLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((zc_i != zc_q) && (angle_i == '0)) |=> !armed); // R6

  AST_CROSS_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_i != zc_q) |=> !gate_o); // R4

  AST_MIN_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> (CW'(cnt_i - cap_q) >= CW'(MIN_DLY))); // R7
endmodule

bind triac_phase_ctrl triac_phase_ctrl_chk #(.CW(CW), .AW(AW), .MIN_DLY(MIN_DLY)) u_chk (.*);

// File: tb/triac_phase_ctrl_tb.sv
module triac_phase_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cnt_i;
  logic        zc_i;
  logic [7:0]  angle_i;
  logic        burst_en_i;
  logic [7:0]  burst_half_i;
  logic        gate_o, fault_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  triac_phase_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .zc_i(zc_i), .angle_i(angle_i),
    .burst_en_i(burst_en_i), .burst_half_i(burst_half_i),
    .gate_o(gate_o), .fault_o(fault_o)
  );

  // {period, angle, burst enable, burst half}
  localparam int VEC [6][4] = '{
    '{3000, 128, 0, 0},
    '{3000, 255, 0, 0},
    '{2500,   1, 0, 0},
    '{ 400, 255, 0, 0},
    '{3000, 200, 1, 4},
    '{3000,   0, 0, 0}
  };

  function automatic string tag_of(int i);
    case (i)
      0: return "R2 R5";
      1: return "R4";
      2: return "R5";
      3: return "R7";
      4: return "R9";
      default: return "R6";
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int guard(int p);
    return (p >> 5) + (p >> 9);
  endfunction

  function automatic int delay_of(int p, int a);
    int g = guard(p);
    int d = g + (((p - 2 * g) * (255 - a)) >> 8);
    return (d < 16) ? 16 : d;
  endfunction

  function automatic int first_of(int p, int a);
    return (a == 0) ? -1 : delay_of(p, a);
  endfunction

  function automatic int highs_of(int p, int a, int b, int h);
    int w, n;
    if (a == 0) return 0;
    w = p - guard(p) - delay_of(p, a);
    if (w <= 0) return 0;
    if (b == 0) return w;
    n = 0;
    for (int i = 0; i < w; i++) if (((i / (h + 1)) % 2) == 0) n++;
    return n;
  endfunction

  task automatic half(input int p, input int a, input int b, input int h, input int a2,
                      output int first, output int highs);
    zc_i = ~zc_i;
    angle_i = a[7:0];
    burst_en_i = b[0];
    burst_half_i = h[7:0];
    first = -1;
    highs = 0;
    for (int j = 0; j < p; j++) begin
      @(posedge clk);
      @(negedge clk);
      if (gate_o) begin
        highs++;
        if (first < 0) first = j;
      end
      if (j == 10) angle_i = a2[7:0];
      cnt_i = cnt_i + 16'd1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int f, hi, f0, f1, g_bad;
    rst_n = 1'b0;
    zc_i = 1'b0;
    cnt_i = 16'hFF00;
    angle_i = 8'd0;
    burst_en_i = 1'b0;
    burst_half_i = 8'd0;
    repeat (3) @(negedge clk);
    check(gate_o == 1'b0, "R1 gate", int'(gate_o), 0);
    check(fault_o == 1'b0, "R1 fault", int'(fault_o), 0);
    rst_n = 1'b1;

    half(3000, 200, 0, 0, 200, f, hi);
    check(hi == 0, "R3", hi, 0);

    for (int i = 0; i < 6; i++) begin
      half(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][1], f, hi);
      half(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][1], f, hi);
      check(f == first_of(VEC[i][0], VEC[i][1]), {tag_of(i), " first"},
            f, first_of(VEC[i][0], VEC[i][1]));
      check(hi == highs_of(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]),
            {tag_of(i), " width"}, hi, highs_of(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]));
    end

    // R8: mid-cycle change takes effect only after the next crossing
    half(3000, 128, 0, 0, 255, f, hi);
    check(f == delay_of(3000, 128), "R8 same half", f, delay_of(3000, 128));
    half(3000, 255, 0, 0, 255, f, hi);
    check(f == delay_of(3000, 255), "R8 next half", f, delay_of(3000, 255));

    // R10: missing crossing
    half(1000, 128, 0, 0, 128, f, hi);
    half(1000, 128, 0, 0, 128, f, hi);
    zc_i = ~zc_i;
    f0 = -1;
    f1 = -1;
    g_bad = 0;
    for (int j = 0; j < 1600; j++) begin
      @(posedge clk);
      @(negedge clk);
      if (j == 1500) f0 = int'(fault_o);
      if (j == 1501) f1 = int'(fault_o);
      if (fault_o && gate_o) g_bad++;
      cnt_i = cnt_i + 16'd1;
    end
    check(f0 == 0, "R10 before limit", f0, 0);
    check(f1 == 1, "R10 at limit", f1, 1);
    check(g_bad == 0, "R10 gate low", g_bad, 0);
    zc_i = ~zc_i;
    @(posedge clk);
    @(negedge clk);
    check(fault_o == 1'b0, "R10 cleared", int'(fault_o), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule